// File: doc/BRIEF.md
# Calibration Test Pulse Sequencer

This block produces the timing for a built-in calibration test of a sixteen-channel charge digitizer. A decoded bus command (function code 25 at subaddress 0, qualified by the data strobe) starts a one-shot window of fixed length. For the whole window the integration gate output is high, so every channel integrates at the same time. A short delay after the gate opens, a discharge-switch enable goes high. That enable dumps a test capacitor into all channel inputs together, so it is fanned out as one identical bit per channel.

The window length and the switch delay are given in nanoseconds: 550 ns and 20 ns by default. They are turned into clock-cycle counts by rounding up against the clock-period parameter. A 20 ns clock therefore gives a 28-cycle window and a 1-cycle switch delay. The window cannot be retriggered. Commands that arrive while it runs are dropped, and a busy output shows that the window is active. The charging amplifier, the capacitor and the resistor fan-out lie outside this block.

Top module: `tsq_test_pulse_seq`

## Requirements
- R1: A window starts on a clock edge only when the block is idle and, at that edge, `bus_strobe` is 1, `bus_func` equals 25 and `bus_sub` equals 0. The gate output is high from that edge on. Any other function code or subaddress, or a low strobe, leaves the block idle.
- R2: The gate output stays high for exactly WIN_CYC = ceil(WINDOW_NS / CLK_PERIOD_NS) consecutive cycles, which is 28 with the defaults.
- R3: The switch enable rises DLY_CYC = ceil(SWITCH_DELAY_NS / CLK_PERIOD_NS) cycles after the gate rises, which is 1 cycle with the defaults. It is never high while the gate is low.
- R4: The switch enable falls on the same clock edge as the gate.
- R5: All NUM_CH bits of `dump_en_o` (16 by default) carry the same value in every cycle.
- R6: A valid command that arrives while the window is active is ignored. It neither lengthens nor restarts the window.
- R7: `busy_o` equals the gate output in every cycle.
- R8: While `rst` is high at a clock edge, the gate, the switch enable and busy go low at that edge. The block stays idle until a new valid command arrives.
- R9: A valid command present at the first edge after a window closes starts a new window. Between two such windows the gate is low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_func | input | 5 | Bus function code |
| bus_sub | input | 4 | Bus subaddress |
| bus_strobe | input | 1 | Strobe qualifying the command |
| gate_o | output | 1 | Integration gate for all channels |
| dump_en_o | output | NUM_CH | Discharge-switch enable, one identical bit per channel |
| busy_o | output | 1 | High while the window is active |

## Verification
The hardest cases to reach are the edges of the window. One is a command that lands on the final gate cycle. Another is a command held continuously, so that the next window starts on the very first idle edge. A command held across a whole window exercises both: it is ignored while the window runs and then starts the next window immediately. The bench holds the strobe with a valid code for several windows and also fires single-cycle commands in the middle of a window. A behavioural model built on an age counter predicts each edge, and the bench compares against it every cycle. A reset in the middle of a window checks that no leftover state starts a window afterwards.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int FUNC_W = 5;
    localparam int SUB_W  = 4;

    localparam logic [FUNC_W-1:0] TEST_FUNC = FUNC_W'(25);
    localparam logic [SUB_W-1:0]  TEST_SUB  = SUB_W'(0);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [SUB_W-1:0]  sub;
        logic              strobe;
    } bus_cmd_t;

    // Round a duration in ns up to whole clock cycles.
    function automatic int ns_to_cycles(input int dur_ns, input int period_ns);
        return (dur_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/tsq_cmd_decode.sv
module tsq_cmd_decode
    import tsq_pkg::*;
(
    input  bus_cmd_t cmd,
    output logic     hit
);
    always_comb begin
        hit = cmd.strobe && (cmd.func == TEST_FUNC) && (cmd.sub == TEST_SUB);
    end
endmodule

// File: rtl/tsq_window_timer.sv
module tsq_window_timer
    import tsq_pkg::*;
#(
    parameter int WIN_CYC = 28,
    parameter int DLY_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic win_on,
    output logic sub_on
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (fire) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == LAST) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign win_on = (state == SEQ_RUN);

    generate
        if (DLY_CYC == 0) begin : g_nodly
            assign sub_on = win_on;
        end else begin : g_dly
            assign sub_on = win_on && (cnt >= CW'(DLY_CYC));
        end
    endgenerate
endmodule

// File: rtl/tsq_fanout.sv
module tsq_fanout #(
    parameter int N = 16
) (
    input  logic         src,
    output logic [N-1:0] dst
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_ch
            assign dst[g] = src;
        end
    endgenerate
endmodule

// File: rtl/tsq_test_pulse_seq.sv
module tsq_test_pulse_seq
    import tsq_pkg::*;
#(
    parameter int CLK_PERIOD_NS   = 20,
    parameter int WINDOW_NS       = 550,
    parameter int SWITCH_DELAY_NS = 20,
    parameter int NUM_CH          = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FUNC_W-1:0] bus_func,
    input  logic [SUB_W-1:0]  bus_sub,
    input  logic              bus_strobe,
    output logic              gate_o,
    output logic [NUM_CH-1:0] dump_en_o,
    output logic              busy_o
);
    localparam int WIN_CYC = ns_to_cycles(WINDOW_NS, CLK_PERIOD_NS);
    localparam int DLY_CYC = ns_to_cycles(SWITCH_DELAY_NS, CLK_PERIOD_NS);

    bus_cmd_t cmd;
    logic     hit;
    logic     win_on;
    logic     sub_on;

    assign cmd = '{func: bus_func, sub: bus_sub, strobe: bus_strobe};

    tsq_cmd_decode u_dec (
        .cmd (cmd),
        .hit (hit)
    );

    tsq_window_timer #(
        .WIN_CYC (WIN_CYC),
        .DLY_CYC (DLY_CYC)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .fire   (hit),
        .win_on (win_on),
        .sub_on (sub_on)
    );

    tsq_fanout #(.N(NUM_CH)) u_fan (
        .src (sub_on),
        .dst (dump_en_o)
    );

    assign gate_o = win_on;
    assign busy_o = win_on;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker
    import tsq_pkg::*;
#(
    parameter int WIN_CYC = 28,
    parameter int DLY_CYC = 1,
    parameter int NUM_CH  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [FUNC_W-1:0] bus_func,
    input logic [SUB_W-1:0]  bus_sub,
    input logic              bus_strobe,
    input logic              gate_o,
    input logic [NUM_CH-1:0] dump_en_o,
    input logic              busy_o
);
    localparam int RW = $clog2(WIN_CYC + 1) + 1;

    logic          cmd_ok;
    logic [RW-1:0] run_len;

    assign cmd_ok = bus_strobe && (bus_func == TEST_FUNC) && (bus_sub == TEST_SUB);

    always_ff @(posedge clk) begin
        if (rst || !gate_o) run_len <= '0;
        else                run_len <= run_len + 1'b1;
    end

    a_r1_start_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> $past(cmd_ok));

    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> (run_len < RW'(WIN_CYC)));

    a_r2_full_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_o) && !$past(rst)) |-> ($past(run_len) == RW'(WIN_CYC - 1)));

    a_r3_sw_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(dump_en_o[0]) |-> (run_len == RW'(DLY_CYC)));

    a_r3_sw_inside: assert property (@(posedge clk) disable iff (rst)
        dump_en_o[0] |-> gate_o);

    a_r4_fall_together: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o) |-> !dump_en_o[0]);

    a_r5_all_equal: assert property (@(posedge clk) disable iff (rst)
        (dump_en_o == '0) || (dump_en_o == '1));

    a_r7_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o == gate_o);
endmodule

bind tsq_test_pulse_seq tsq_checker #(
    .WIN_CYC (WIN_CYC),
    .DLY_CYC (DLY_CYC),
    .NUM_CH  (NUM_CH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_func   (bus_func),
    .bus_sub    (bus_sub),
    .bus_strobe (bus_strobe),
    .gate_o     (gate_o),
    .dump_en_o  (dump_en_o),
    .busy_o     (busy_o)
);

// File: tb/sim_tsq_test_pulse_seq.sv
`timescale 1ns/1ps
module sim_tsq_test_pulse_seq;
    localparam int PER = 20;
    localparam int NCH = 16;
    localparam int WIN = (550 + PER - 1) / PER;  // 28
    localparam int DLY = (20 + PER - 1) / PER;   // 1

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [4:0]     bus_func = '0;
    logic [3:0]     bus_sub = '0;
    logic           bus_strobe = 1'b0;
    logic           gate_o;
    logic [NCH-1:0] dump_en_o;
    logic           busy_o;

    int checks = 0;
    int errors = 0;
    int age = -1;      // model: cycles since window start, -1 when idle
    int gate_q[$];     // recent gate samples

    always #(PER/2) clk = ~clk;

    tsq_test_pulse_seq u0 (
        .clk(clk), .rst(rst), .bus_func(bus_func), .bus_sub(bus_sub),
        .bus_strobe(bus_strobe), .gate_o(gate_o), .dump_en_o(dump_en_o),
        .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        bit hit;
        @(posedge clk);
        hit = bus_strobe && bus_func == 5'd25 && bus_sub == 4'd0;
        if (rst) age = -1;
        else if (age < 0) begin
            if (hit) age = 0;
        end else begin
            age++;
            if (age == WIN) age = -1;
        end
        @(negedge clk);
        chk(gate_o == (age >= 0), "R2 gate vs model", int'(gate_o), int'(age >= 0));
        chk(dump_en_o[0] == (age >= DLY), "R3/R4 switch vs model",
            int'(dump_en_o[0]), int'(age >= DLY));
        chk(dump_en_o == '0 || dump_en_o == '1, "R5 channels equal",
            int'(dump_en_o), 0);
        chk(busy_o == gate_o, "R7 busy equals gate", int'(busy_o), int'(gate_o));
        gate_q.push_back(int'(gate_o));
        if (gate_q.size() > 4) void'(gate_q.pop_front());
    endtask

    task automatic cmd(input logic [4:0] f, input logic [3:0] s, input logic st);
        bus_func = f; bus_sub = s; bus_strobe = st;
    endtask

    // Pulse a valid command for one cycle, then measure the window.
    task automatic fire_and_measure(input int retrig_at, output int hi, output int sw_off,
                                    output bit fell_ok);
        cmd(5'd25, 4'd0, 1'b1);
        step();
        cmd(5'd0, 4'd0, 1'b0);
        hi = 0; sw_off = -1; fell_ok = 1'b1;
        while (gate_o && hi < 100) begin
            if (dump_en_o[0] && sw_off < 0) sw_off = hi;
            hi++;
            if (hi == retrig_at) cmd(5'd25, 4'd0, 1'b1);
            else cmd(5'd0, 4'd0, 1'b0);
            step();
        end
        cmd(5'd0, 4'd0, 1'b0);
        fell_ok = (dump_en_o == '0);
    endtask

    initial begin
        int hi, sw_off, lows, wins;
        bit fell_ok;
        rst = 1'b1;
        repeat (3) step();
        chk(gate_o == 1'b0 && dump_en_o == '0 && busy_o == 1'b0, "R8 reset state",
            int'(gate_o), 0);
        rst = 1'b0;
        step();

        // R1: near-miss commands must not start a window
        cmd(5'd24, 4'd0, 1'b1); repeat (4) step();
        chk(gate_o == 1'b0, "R1 wrong function ignored", int'(gate_o), 0);
        cmd(5'd25, 4'd1, 1'b1); repeat (4) step();
        chk(gate_o == 1'b0, "R1 wrong subaddress ignored", int'(gate_o), 0);
        cmd(5'd25, 4'd0, 1'b0); repeat (4) step();
        chk(gate_o == 1'b0, "R1 no strobe ignored", int'(gate_o), 0);

        // R1/R2/R3/R4: clean window
        fire_and_measure(-1, hi, sw_off, fell_ok);
        chk(hi == WIN, "R2 window length", hi, WIN);
        chk(sw_off == DLY, "R3 switch delay", sw_off, DLY);
        chk(fell_ok, "R4 switch falls with gate", int'(fell_ok), 1);
        repeat (3) step();

        // R6: retrigger mid-window and on the last cycle
        fire_and_measure(10, hi, sw_off, fell_ok);
        chk(hi == WIN, "R6 mid-window retrigger ignored", hi, WIN);
        repeat (3) step();
        fire_and_measure(WIN - 1, hi, sw_off, fell_ok);
        chk(hi == WIN, "R6 last-cycle retrigger ignored", hi, WIN);
        repeat (3) step();

        // R9: command held -> back-to-back windows with one low cycle
        cmd(5'd25, 4'd0, 1'b1);
        lows = 0; wins = 0;
        for (int i = 0; i < 3 * WIN + 4; i++) begin
            step();
            if (i > 0 && !gate_o) lows++;
            if (gate_q.size() >= 2 && gate_q[gate_q.size()-1] == 1 &&
                gate_q[gate_q.size()-2] == 0) wins++;
        end
        cmd(5'd0, 4'd0, 1'b0);
        chk(lows == 3, "R9 single low cycle between windows", lows, 3);
        chk(wins >= 3, "R9 windows restarted", wins, 3);
        repeat (WIN + 2) step();

        // R8: reset in mid-window
        cmd(5'd25, 4'd0, 1'b1); step(); cmd(5'd0, 4'd0, 1'b0);
        repeat (8) step();
        rst = 1'b1; step(); rst = 1'b0;
        chk(gate_o == 1'b0 && dump_en_o == '0, "R8 reset clears window", int'(gate_o), 0);
        repeat (WIN) step();
        chk(gate_o == 1'b0, "R8 stays idle after reset", int'(gate_o), 0);

        // R5: channels equal inside a window
        cmd(5'd25, 4'd0, 1'b1); step(); cmd(5'd0, 4'd0, 1'b0);
        repeat (5) step();
        chk(dump_en_o == '1, "R5 all channels enabled", int'(dump_en_o), 16'hFFFF);
        repeat (WIN + 2) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule